// File: doc/BRIEF.md
# Compare-Match PWM Timer

This block is an up-counting timer that produces a fixed-period pulse-width modulated signal on one output. A single-cycle count pulse, derived elsewhere from the system clock, advances the counter; an enable input starts and stops counting. The counter runs from zero to its full count and then wraps, so one period is 2^WIDTH count ticks (256 for the default 8-bit width). A duty value sets how long the waveform stays high in each period. The high phase begins at count zero and includes the count equal to the duty value.

The waveform is formed from the counter value before each tick and is captured into an output register on that tick. The output therefore lags the internal waveform by exactly one count tick. Duty writes land in a holding buffer. The buffer is copied into the active compare register only at a period boundary, or on any tick while the timer is stopped. A period is never cut short or stretched by a write in the middle of it.

Top module: `cmp_pwm_timer`

## Requirements
- R1: While `rst_n` is low, the counter, active compare, holding buffer and `pwm_out` are all zero, and `pwm_out` reads 0.
- R2: On each system-clock edge with `tick` and `run` high, the counter rises by one and wraps from all-ones to zero, so a period lasts 2^WIDTH ticks.
- R3: After a running tick, `pwm_out` is 1 exactly when the counter value before that tick was less than or equal to the active compare value N. With N held, `pwm_out` is high for N+1 of the 2^WIDTH ticks of each period.
- R4: With an active compare value of all-ones, `pwm_out` stays 1 on every running tick. With a value of zero, it is high for exactly one tick per period.
- R5: A write (`duty_wr` high) loads only the holding buffer. The active compare value takes the buffer contents on a running tick whose pre-tick count is all-ones, so a write in mid-period leaves the rest of that period unchanged.
- R6: A tick with `run` low sets the counter to zero and `pwm_out` to 0, and copies the holding buffer into the active compare register.
- R7: On a system-clock edge with `tick` low, the counter, the active compare value and `pwm_out` keep their values.
- R8: After the timer is stopped and then restarted, `pwm_out` goes to 1 on the first running tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count pulse, one system clock wide |
| run | input | 1 | Timer enable; counting only while high |
| duty_wr | input | 1 | Write strobe for the duty holding buffer |
| duty_din | input | WIDTH | Duty value to be written |
| pwm_out | output | 1 | PWM output, one tick behind the internal waveform |

## Verification
The checker watches the per-tick rules on every clock: counter stepping and wrap, the one-tick relation between the pre-tick count and the output, the cleared state after a stopped tick, and the hold of every register on edges without a tick. It also checks that the active compare value changes only at a period boundary or while stopped. Whole-period results can only be shown by the bench's scenarios. These include the high-tick counts of N+1 for zero, mid-range and all-ones duty values, a write in mid-period that takes effect only in the following period, and the first high tick after a restart. Random tick, enable and write patterns are compared against a reference model in the bench.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  // Level of the internally formed waveform before the output register
  typedef enum logic {
    PHASE_LOW  = 1'b0,
    PHASE_HIGH = 1'b1
  } phase_e;

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  output logic [WIDTH-1:0] cnt,
  output logic             at_full
);

  localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = tick;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt     = cnt_q;
  assign at_full = (cnt_q == FULL);

endmodule

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [WIDTH-1:0] din,
  input  logic             load,
  output logic [WIDTH-1:0] cmp_act
);

  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] hold_d;
  logic [WIDTH-1:0] act_q;
  logic [WIDTH-1:0] act_d;

  always_comb begin
    hold_d = wr ? din : hold_q;
    act_d  = load ? hold_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr) begin
        hold_q <= hold_d;
      end
      if (load) begin
        act_q <= act_d;
      end
    end
  end

  assign cmp_act = act_q;

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
  import pwm_timer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [WIDTH-1:0] cnt,
  input  logic [WIDTH-1:0] cmp_act,
  output logic             pwm
);

  phase_e src_phase;
  logic   out_q;
  logic   out_d;

  // Source waveform: high from zero up to and including the compare value
  always_comb begin
    src_phase = (cnt <= cmp_act) ? PHASE_HIGH : PHASE_LOW;
    out_d     = run && (src_phase == PHASE_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else if (tick) begin
      out_q <= out_d;
    end
  end

  assign pwm = out_q;

endmodule

// File: rtl/cmp_pwm_timer.sv
module cmp_pwm_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             duty_wr,
  input  logic [WIDTH-1:0] duty_din,
  output logic             pwm_out
);

  logic [WIDTH-1:0] cnt;
  logic             at_full;
  logic [WIDTH-1:0] cmp_act;
  logic             cmp_load;

  // Compare update at the period boundary, or on any stopped tick
  assign cmp_load = tick && (!run || at_full);

  pwm_counter #(.WIDTH(WIDTH)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run     (run),
    .cnt     (cnt),
    .at_full (at_full)
  );

  pwm_duty_buf #(.WIDTH(WIDTH)) u_duty (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (duty_wr),
    .din     (duty_din),
    .load    (cmp_load),
    .cmp_act (cmp_act)
  );

  pwm_wave #(.WIDTH(WIDTH)) u_wave (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run     (run),
    .cnt     (cnt),
    .cmp_act (cmp_act),
    .pwm     (pwm_out)
  );

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             run,
  input logic [WIDTH-1:0] cnt,
  input logic [WIDTH-1:0] cmp_act,
  input logic             pwm_out
);

  localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

  always_comb begin
    if (!rst_n) begin
      AST_RESET_LOW: assert (!pwm_out && cnt == '0 && cmp_act == '0); // R1
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run) |=> (cnt == $past(cnt) + 1'b1)); // R2

  AST_OUT_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run) |=> (pwm_out == ($past(cnt) <= $past(cmp_act)))); // R3

  AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && cmp_act == FULL) |=> pwm_out); // R4

  AST_CMP_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && (!run || cnt == FULL))) |=> $stable(cmp_act)); // R5

  AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !run) |=> (cnt == '0 && !pwm_out)); // R6

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(cnt) && $stable(pwm_out) && $stable(cmp_act))); // R7

  AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && cnt == '0) |=> pwm_out); // R8

endmodule

bind cmp_pwm_timer pwm_timer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .run     (run),
  .cnt     (cnt),
  .cmp_act (cmp_act),
  .pwm_out (pwm_out)
);

// File: tb/tb_cmp_pwm_timer.sv
module tb_cmp_pwm_timer;

  localparam int W    = 8;
  localparam int PER  = 1 << W;

  logic         clk;
  logic         rst_n;
  logic         tick;
  logic         run;
  logic         duty_wr;
  logic [W-1:0] duty_din;
  logic         pwm_out;

  int checks;
  int errors;
  bit done;

  // Reference state
  logic [W-1:0] m_cnt, m_act, m_hold;
  logic         m_pwm;

  cmp_pwm_timer #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .duty_wr(duty_wr), .duty_din(duty_din), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_level(input logic [W-1:0] c, input logic [W-1:0] n);
    return c <= n;
  endfunction

  // One system clock: drive, update model, sample at the falling edge
  task automatic step(input bit t, input bit r, input bit w, input logic [W-1:0] d,
                      input string req);
    logic [W-1:0] old_hold;
    tick = t; run = r; duty_wr = w; duty_din = d;
    @(posedge clk);
    old_hold = m_hold;
    if (w) m_hold = d;
    if (t) begin
      if (!r) begin
        m_cnt = '0; m_pwm = 1'b0; m_act = old_hold;
      end else begin
        m_pwm = exp_level(m_cnt, m_act);
        if (m_cnt == {W{1'b1}}) m_act = old_hold;
        m_cnt = m_cnt + 1'b1;
      end
    end
    @(negedge clk);
    check(pwm_out == m_pwm, req, pwm_out, m_pwm);
  endtask

  // Load a duty value and stop, so the next period starts from zero
  task automatic setup_duty(input logic [W-1:0] n);
    step(1'b0, 1'b0, 1'b1, n, "R5");
    step(1'b1, 1'b0, 1'b0, '0, "R6");
  endtask

  // Count high ticks over one full period of running ticks
  task automatic period_high(output int hi, input string req);
    hi = 0;
    for (int i = 0; i < PER; i++) begin
      step(1'b1, 1'b1, 1'b0, '0, req);
      if (pwm_out) hi++;
    end
  endtask

  initial begin
    int hi;
    checks = 0; errors = 0; done = 0;
    void'($urandom(32'd1234));
    tick = 0; run = 0; duty_wr = 0; duty_din = '0;
    m_cnt = '0; m_act = '0; m_hold = '0; m_pwm = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(pwm_out == 1'b0, "R1", pwm_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_out == 1'b0, "R1", pwm_out, 0);

    // R3: mid-range duty, N+1 high ticks
    setup_duty(8'd100);
    period_high(hi, "R3");
    check(hi == 101, "R3", hi, 101);

    // R4: all-ones duty always high, zero duty one tick
    setup_duty(8'hFF);
    period_high(hi, "R4");
    check(hi == PER, "R4", hi, PER);
    setup_duty(8'h00);
    period_high(hi, "R4");
    check(hi == 1, "R4", hi, 1);

    // R8: first running tick after restart is high
    setup_duty(8'd3);
    step(1'b1, 1'b1, 1'b0, '0, "R8");
    check(pwm_out == 1'b1, "R8", pwm_out, 1);

    // R5: mid-period write does not affect current period
    setup_duty(8'd10);
    hi = 0;
    for (int i = 0; i < PER; i++) begin
      step(1'b1, 1'b1, (i == 50), 8'd200, "R5");
      if (pwm_out) hi++;
    end
    check(hi == 11, "R5", hi, 11);
    period_high(hi, "R5");
    check(hi == 201, "R5", hi, 201);

    // R7: no tick leaves output unchanged
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b0, '0, "R7");

    // R6: stopped tick clears output
    step(1'b1, 1'b1, 1'b0, '0, "R6");
    step(1'b1, 1'b0, 1'b0, '0, "R6");
    check(pwm_out == 1'b0, "R6", pwm_out, 0);

    // R2: constrained random ticks, enable and writes vs. model
    for (int i = 0; i < 20000; i++) begin
      bit t, r, w;
      t = ($urandom % 3) != 0;
      r = ($urandom % 50) != 0;
      w = ($urandom % 40) == 0;
      step(t, r, w, W'($urandom), "R2");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule